// File: doc/BRIEF.md
# Data-strobe serial receive decoder

This block sits behind one cable port of a serial bus node and turns the two received logic lines back into parallel data for the link side. On receive the data travels on the A line and the strobe on the B line. A bit boundary is any change in the exclusive-OR of the two lines. At each such change the level of the A line is the value of the new bit.

Both lines pass through a two-flop synchronizer in the fast sampling domain. Recovered bits are shifted in with the earliest bit ending up in the most significant position. In the slow-speed mode they are grouped into two-bit words, and in the fast-speed mode into four-bit words. Each finished word is handed to the system-clock domain, where it appears with a valid pulse lasting one system cycle.

While a packet is in progress the block reports itself as receiving. The same condition drives the output that switches off the port's own transmitters. A run of quiet sampling cycles closes the packet, and any bits left over that do not fill a word are thrown away. The system clock is one quarter of the sampling clock, is derived from it, and has its rising edge in the middle of a sampling cycle.

Top module: `ds_rx_decoder`

## Requirements
- R1: `tx_off` is 1 exactly while `rx_active` is 1, so the transmitters are off for the whole of a reception; a partly collected word never exists while `rx_active` is 0.
- R2: The bit value is taken from `line_a` (data); `line_b` carries the strobe only and never supplies a bit value.
- R3: Every change of `line_a XOR line_b`, once synchronized, yields exactly one received bit; at most one bit is accepted per sampling cycle.
- R4: With `speed_hi` = 0, bits are grouped in pairs: the first bit of the pair goes to `word_out[1]`, the second to `word_out[0]`, and `word_out[3:2]` is 0.
- R5: With `speed_hi` = 1, bits are grouped in fours: the first bit goes to `word_out[3]` and the last to `word_out[0]`.
- R6: Each completed word produces exactly one `word_valid` pulse of one `clk_sys` cycle, and words come out in the order they were received, with no loss even when they complete back to back.
- R7: When the lines show no parity change for IDLE_CYC (8) consecutive sampling cycles after a bit, `rx_active` clears and any partly collected word is discarded; the next bit starts a fresh word.
- R8: A bit held for up to IDLE_CYC sampling cycles keeps the packet open and the word grouping continues across it.
- R9: After reset `rx_active`, `tx_off` and `word_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Sampling clock (four times the system clock) |
| clk_sys | input | 1 | System clock, rising edge mid-way through a sampling cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_hi | input | 1 | 0: two-bit words, 1: four-bit words; changed only between packets |
| line_a | input | 1 | Received data line |
| line_b | input | 1 | Received strobe line |
| rx_active | output | 1 | Packet being received (sampling domain) |
| tx_off | output | 1 | Disables the port transmitters while receiving |
| word_out | output | 4 | Received word, valid with `word_valid` (system domain) |
| word_valid | output | 1 | One-cycle pulse per received word (system domain) |

## Verification
The bench encodes every possible word value at both speeds, MSB first, and compares the output stream word by word against the expected sequence. A decoder that swapped the lines, reversed the bit order or mixed up the widths would show wrong values. One that missed a word handed over in back-to-back system cycles would leave expected words unmatched. Bits held for exactly the quiet limit must keep the grouping intact, and a decoder that closed the packet one cycle early would split a word. Bits held one cycle longer must end the packet, so a decoder that kept a partial word would show every later word shifted.

// File: rtl/ds_rx_decoder.sv
module ds_rx_decoder #(
  parameter int IDLE_CYC = 8
) (
  input  logic       clk_fast,
  input  logic       clk_sys,
  input  logic       rst_n,
  input  logic       speed_hi,
  input  logic       line_a,
  input  logic       line_b,
  output logic       rx_active,
  output logic       tx_off,
  output logic [3:0] word_out,
  output logic       word_valid
);
  localparam int CW = $clog2(IDLE_CYC);

  logic [1:0]    a_s, b_s;
  logic          par_q;
  logic [3:0]    sh;
  logic [1:0]    nbits;
  logic [CW-1:0] idle_cnt;
  logic [3:0]    word_hold;
  logic          tgl;

  wire       par    = a_s[1] ^ b_s[1];
  wire       edge_d = par ^ par_q;
  wire [3:0] nsh    = {sh[2:0], a_s[1]};
  wire [1:0] last   = speed_hi ? 2'd3 : 2'd1;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      a_s <= '0; b_s <= '0; par_q <= 1'b0;
      sh <= '0; nbits <= '0; idle_cnt <= '0;
      word_hold <= '0; tgl <= 1'b0; rx_active <= 1'b0;
    end else begin
      a_s   <= {a_s[0], line_a};
      b_s   <= {b_s[0], line_b};
      par_q <= par;
      if (edge_d) begin
        rx_active <= 1'b1;
        idle_cnt  <= '0;
        sh        <= nsh;
        if (nbits == last) begin
          word_hold <= speed_hi ? nsh : {2'b00, nsh[1:0]};
          tgl       <= ~tgl;
          nbits     <= '0;
        end else begin
          nbits <= nbits + 2'd1;
        end
      end else if (rx_active) begin
        if (idle_cnt == CW'(IDLE_CYC - 1)) begin
          rx_active <= 1'b0;
          nbits     <= '0;
          idle_cnt  <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end

  assign tx_off = rx_active;

  logic tgl_s, tgl_s2;
  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      tgl_s <= 1'b0; tgl_s2 <= 1'b0; word_out <= '0;
    end else begin
      tgl_s    <= tgl;
      tgl_s2   <= tgl_s;
      word_out <= word_hold;
    end
  end

  assign word_valid = tgl_s ^ tgl_s2;

  assert_edge_opens_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    edge_d |=> rx_active);
  assert_quiet_closes_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (rx_active && !edge_d && idle_cnt == CW'(IDLE_CYC - 1)) |=> (!rx_active && nbits == 2'd0));
  assert_partial_needs_active_R1: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (nbits != 2'd0) |-> tx_off);
  assert_narrow_upper_zero_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (edge_d && !speed_hi && nbits == 2'd1) |=> (word_hold[3:2] == 2'b00));
  assert_narrow_count_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (!speed_hi && !$past(speed_hi)) |-> (nbits <= 2'd1));
endmodule

// File: tb/ds_rx_decoder_tb.sv
module ds_rx_decoder_tb_top;
  logic clk_fast = 1'b0, clk_sys = 1'b0, rst_n = 1'b0, speed_hi = 1'b0;
  logic enc_d = 1'b0, enc_s = 1'b0;
  logic rx_active, tx_off, word_valid;
  logic [3:0] word_out;

  int checks = 0, errors = 0;
  logic [3:0] exp_q [0:255];
  int wr = 0, rd = 0;
  logic [3:0] acc = '0;
  int nacc = 0;
  logic done = 1'b0;

  ds_rx_decoder dut_i (
    .clk_fast(clk_fast), .clk_sys(clk_sys), .rst_n(rst_n), .speed_hi(speed_hi),
    .line_a(enc_d), .line_b(enc_s), .rx_active(rx_active), .tx_off(tx_off),
    .word_out(word_out), .word_valid(word_valid));

  always #5 clk_fast = ~clk_fast;
  initial begin
    #10;
    forever begin clk_sys = 1'b1; #20; clk_sys = 1'b0; #20; end
  end

  // R6 scoreboard: every valid word in order, one pulse each
  always @(negedge clk_sys) if (rst_n && word_valid) begin
    checks++;
    if (rd >= wr) begin
      errors++;
      $display("FAIL R6 unexpected word actual=%h expected=none", word_out);
    end else begin
      if (word_out !== exp_q[rd]) begin
        errors++;
        $display("FAIL R2/R4/R5 word %0d actual=%h expected=%h", rd, word_out, exp_q[rd]);
      end
      rd++;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic d, input int h);
    @(negedge clk_fast);
    enc_s = enc_s ^ (d ~^ enc_d);
    enc_d = d;
    acc = {acc[2:0], d};
    nacc++;
    if (nacc == (speed_hi ? 4 : 2)) begin
      exp_q[wr] = speed_hi ? acc : {2'b00, acc[1:0]};
      wr++;
      nacc = 0;
    end
    if (h > 8) nacc = 0;
    repeat (h - 1) @(negedge clk_fast);
  endtask

  task automatic send_word(input logic [3:0] v, input int h);
    for (int i = (speed_hi ? 3 : 1); i >= 0; i--) send_bit(v[i], h);
  endtask

  task automatic end_packet();
    repeat (20) @(negedge clk_fast);
    check("R7 rx_active cleared", rx_active, 1'b0);
    check("R1 tx_off cleared", tx_off, 1'b0);
    nacc = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_fast);
    check("R9 rx_active reset", rx_active, 1'b0);
    check("R9 tx_off reset", tx_off, 1'b0);
    check("R9 word_valid reset", word_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_fast);

    for (int sp = 1; sp >= 0; sp--) begin
      speed_hi = sp[0];
      // full sweep of word values at maximum bit rate, back to back
      for (int v = 0; v < 16; v++) begin
        send_word(v[3:0], sp ? 1 : 2);
        if (v == 2) begin
          check("R1 rx_active during packet", rx_active, 1'b1);
          check("R1 tx_off during packet", tx_off, 1'b1);
        end
      end
      end_packet();
      // R8: bits held for the full quiet limit keep the grouping
      for (int v = 0; v < 16; v++) send_word(4'(15 - v), 8);
      end_packet();
      // R7: a long hold ends the packet after a partial word
      send_word(4'h9, 1);
      send_bit(1'b1, 12);
      check("R7 packet closed by long hold", rx_active, 1'b0);
      for (int v = 0; v < 16; v++) send_word(4'(v ^ 5), 2);
      send_bit(1'b0, 1);
      end_packet();
    end

    repeat (40) @(negedge clk_fast);
    checks++;
    if (rd != wr) begin
      errors++;
      $display("FAIL R6 words received actual=%0d expected=%0d", rd, wr);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule